// File: doc/BRIEF.md
# Parallel Slave Configuration Load Port

This block is the slave side of a parallel port that loads configuration data into a programmable device and reads it back. An external host owns the port clock, an active-low select and a read/write direction line. With the port selected and the direction line low, each accepted bus word goes straight to a downstream sink with a ready/valid handshake. With the direction line high, words are taken from an upstream readback source and driven back onto the bus. The bitstream parser, CRC and configuration memory are not part of the block; the sink and the source stand in for them.

The bidirectional data bus and the BUSY pin are split at the pad into separate input, output and output-enable signals. When the port is deselected, both enables are low, so the pins float, and the block ignores all inputs. A change of the direction line while the port stays selected is illegal. When the next rising edge arrives, the port enters an abort state. The host can clear that state only by deselecting the port for at least one edge. The bus width is set by a parameter and may be 8, 16 or 32 bits.

Top module: `cfg_par_port`

## Requirements
- R1: While `sel_n` is high, `bus_oe` and `busy_oe` are low, `snk_valid` and `src_ready` are low, and a rising edge changes no output that is visible once the port is selected again.
- R2: In a cycle where `sel_n` is low, `dir_rd` is low (0 = write), no abort is pending, the direction has not just flipped and `snk_ready` is high, `snk_valid` is high and `snk_data` equals `bus_i`.
- R3: In a selected write cycle with `snk_ready` low, `busy_o` is high and `snk_valid` is low, so no word is taken.
- R4: If the port was selected at the previous rising edge and is still selected, and `dir_rd` now differs from its value at that edge, then no word moves in this cycle, `busy_o` is high, and `abort_o` is high after the next rising edge.
- R5: Once set, `abort_o` stays high on every rising edge where `sel_n` is low. It clears on the first rising edge where `sel_n` is high. While it is set, no sink or source transfer happens and `busy_o` is high.
- R6: `bus_oe` goes high only after a rising edge at which the port was selected in read direction (`dir_rd` = 1) with no abort. It stays high while that condition holds. `src_ready` is high in each such cycle, and a word that the source offers is loaded at that edge and appears on `bus_o`.
- R7: `rd_vld` is high exactly when `bus_oe` is high and the last read edge loaded a source word. If the source offered nothing at that edge, `rd_vld` is low.
- R8: Continuous loading (select held low) and non-continuous loading (select released between words) both deliver every accepted word to the sink, in bus order, with no loss and no duplication.
- R9: After reset, `abort_o`, `bus_oe` and `rd_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock driven by the external host |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low port select |
| dir_rd | input | 1 | Direction: 0 = host writes, 1 = host reads |
| bus_i | input | BUS_W | Data bus, pad input side |
| bus_o | output | BUS_W | Data bus, pad output side |
| bus_oe | output | 1 | Data bus output enable |
| busy_o | output | 1 | BUSY pin value |
| busy_oe | output | 1 | BUSY pin output enable |
| abort_o | output | 1 | Abort state flag |
| rd_vld | output | 1 | The driven readback word is good |
| snk_valid | output | 1 | Word offered to the configuration sink |
| snk_data | output | BUS_W | Word to the sink |
| snk_ready | input | 1 | Sink can take a word |
| src_valid | input | 1 | Readback source offers a word |
| src_data | input | BUS_W | Readback word |
| src_ready | output | 1 | Port takes the offered source word |

## Verification
A stale previous-direction register or a stuck abort flag shows at the ports in the same cycle or at the next edge. A missed flip leaves `busy_o` low and lets a word into the sink in the flip cycle. An abort flag that never clears keeps `snk_valid` low after a proper deselect. A wrong output-enable register makes `bus_oe` rise one edge early or late on the first read. A readback register that is loaded without the source handshake shows up as a `bus_o` word the reference did not pop, or as a wrong `rd_vld`. Because the reference model is compared every cycle, each of these faults is caught within one clock of the bad state.

// File: rtl/cfg_par_port_pkg.sv
package cfg_par_port_pkg;

  typedef enum logic [1:0] {
    LANE_IDLE  = 2'd0,
    LANE_WRITE = 2'd1,
    LANE_READ  = 2'd2,
    LANE_ABORT = 2'd3
  } lane_e;

  // Illegal direction change: selected now and at the last edge, direction differs.
  function automatic logic dir_flipped(input logic sel_now, input logic sel_prev,
                                       input logic dir_now, input logic dir_prev);
    return sel_now & sel_prev & (dir_now ^ dir_prev);
  endfunction

  // Per-cycle port mode from the pins and the guard state.
  function automatic lane_e lane_of(input logic sel_now, input logic dir_now,
                                    input logic abort_now, input logic flip_now);
    if (!sel_now)                return LANE_IDLE;
    else if (abort_now || flip_now) return LANE_ABORT;
    else if (dir_now)             return LANE_READ;
    else                          return LANE_WRITE;
  endfunction

endpackage

// File: rtl/cfg_dir_guard.sv
module cfg_dir_guard
  import cfg_par_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic dir_rd,
  output logic flip,
  output logic abort_q
);

  logic sel_prev_q;
  logic dir_prev_q;

  assign flip = dir_flipped(sel, sel_prev_q, dir_rd, dir_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q <= 1'b0;
      dir_prev_q <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      sel_prev_q <= sel;
      if (sel) dir_prev_q <= dir_rd;
      if (!sel)      abort_q <= 1'b0;
      else if (flip) abort_q <= 1'b1;
    end
  end

  // R4: a flip while selected leaves the abort flag set after the edge
  a_r4_flip_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> abort_q);

  // R5: abort holds while still selected
  a_r5_abort_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && sel) |=> abort_q);

  // R5: one deselected edge clears it
  a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !abort_q);

endmodule

// File: rtl/cfg_write_lane.sv
module cfg_write_lane
  import cfg_par_port_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_e            mode,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             snk_ready,
  output logic             snk_valid,
  output logic [BUS_W-1:0] snk_data,
  output logic             stall
);

  assign snk_valid = (mode == LANE_WRITE) && snk_ready;
  assign snk_data  = bus_i;
  assign stall     = (mode == LANE_WRITE) && !snk_ready;

  // R3: a stalled write never offers a word
  a_r3_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !snk_valid);

  // R5: nothing reaches the sink in the abort lane
  a_r5_no_write_in_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LANE_ABORT) |-> !snk_valid);

endmodule

// File: rtl/cfg_read_lane.sv
module cfg_read_lane
  import cfg_par_port_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_e            mode,
  input  logic             src_valid,
  input  logic [BUS_W-1:0] src_data,
  output logic             src_ready,
  output logic             drive_q,
  output logic             word_q,
  output logic [BUS_W-1:0] rdata_q
);

  logic take;

  assign src_ready = (mode == LANE_READ);
  assign take      = src_ready && src_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      word_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      drive_q <= src_ready;
      word_q  <= take;
      if (take) rdata_q <= src_data;
    end
  end

  // R6: driving starts only after a read-lane edge
  a_r6_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |-> $past(mode == LANE_READ));

  // R7: a good word needs a completed source handshake at the previous edge
  a_r7_word_from_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    word_q |-> $past(src_valid && src_ready));

endmodule

// File: rtl/cfg_par_port.sv
module cfg_par_port
  import cfg_par_port_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             dir_rd,
  input  logic [BUS_W-1:0] bus_i,
  output logic [BUS_W-1:0] bus_o,
  output logic             bus_oe,
  output logic             busy_o,
  output logic             busy_oe,
  output logic             abort_o,
  output logic             rd_vld,
  output logic             snk_valid,
  output logic [BUS_W-1:0] snk_data,
  input  logic             snk_ready,
  input  logic             src_valid,
  input  logic [BUS_W-1:0] src_data,
  output logic             src_ready
);

  localparam bit WIDTH_OK = (BUS_W == 8) || (BUS_W == 16) || (BUS_W == 32);

  logic  sel;
  logic  flip;
  logic  abort_q;
  logic  stall;
  logic  drive_q;
  logic  word_q;
  lane_e mode;

  assign sel  = !sel_n;
  assign mode = lane_of(sel, dir_rd, abort_q, flip);

  cfg_dir_guard u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .dir_rd  (dir_rd),
    .flip    (flip),
    .abort_q (abort_q)
  );

  cfg_write_lane #(.BUS_W(BUS_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .bus_i     (bus_i),
    .snk_ready (snk_ready),
    .snk_valid (snk_valid),
    .snk_data  (snk_data),
    .stall     (stall)
  );

  cfg_read_lane #(.BUS_W(BUS_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .drive_q   (drive_q),
    .word_q    (word_q),
    .rdata_q   (bus_o)
  );

  assign bus_oe  = drive_q && (mode == LANE_READ);
  assign rd_vld  = bus_oe && word_q;
  assign busy_oe = sel;
  assign busy_o  = (mode == LANE_ABORT) || stall;
  assign abort_o = abort_q;

  // Bus width must be one of the supported widths
  initial a_width_legal: assert (WIDTH_OK);

  // R1: a deselected port drives nothing and moves nothing
  a_r1_float: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (!bus_oe && !busy_oe && !snk_valid && !src_ready));

  // R4: the flip cycle itself reports busy and moves no word
  a_r4_flip_cycle_busy: assert property (@(posedge clk) disable iff (!rst_n)
    flip |-> (busy_o && !snk_valid && !src_ready));

  // R5: abort keeps the bus undriven
  a_r5_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!bus_oe && !src_ready));

endmodule

// File: tb/cfg_par_port_test.sv
module cfg_par_port_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_n = 1'b1, dir_rd = 1'b0, snk_ready = 1'b0, src_valid = 1'b0;
  logic [W-1:0] bus_i = '0, src_data = '0;
  logic [W-1:0] bus_o, snk_data;
  logic         bus_oe, busy_o, busy_oe, abort_o, rd_vld, snk_valid, src_ready;

  always #10 clk = ~clk;

  cfg_par_port #(.BUS_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir_rd(dir_rd),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .busy_o(busy_o),
    .busy_oe(busy_oe), .abort_o(abort_o), .rd_vld(rd_vld),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready));

  int errors = 0, checks = 0, cycles = 0;
  logic [W-1:0] srcq[$];
  logic [W-1:0] expq[$];
  logic [W-1:0] gotq[$];
  logic         src_gate = 1'b1;

  // reference state
  logic m_psel = 0, m_pdir = 0, m_abort = 0, m_drv = 0, m_rv = 0;
  logic [W-1:0] m_rq = '0;

  function automatic logic m_flip();
    return !sel_n && m_psel && (dir_rd != m_pdir);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      logic f, rd_ok;
      f = m_flip();
      rd_ok = !sel_n && dir_rd && !m_abort && !f;
      if (!sel_n && !dir_rd && !m_abort && !f && snk_ready) expq.push_back(bus_i);
      if (snk_valid && snk_ready) gotq.push_back(snk_data);
      m_drv = rd_ok;
      m_rv  = rd_ok && src_valid;
      if (rd_ok && src_valid) begin
        m_rq = src_data;
        void'(srcq.pop_front());
      end
      if (sel_n) m_abort = 1'b0;
      else if (f) m_abort = 1'b1;
      m_psel = !sel_n;
      if (!sel_n) m_pdir = dir_rd;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic compare();
    logic f, sel, oe, wr;
    f   = m_flip();
    sel = !sel_n;
    oe  = m_drv && sel && dir_rd && !m_abort && !f;
    wr  = sel && !dir_rd && !m_abort && !f;
    chk("R1 busy_oe", busy_oe, sel);
    chk("R6 bus_oe", bus_oe, oe);
    chk("R6 src_ready", src_ready, sel && dir_rd && !m_abort && !f);
    chk("R7 rd_vld", rd_vld, oe && m_rv);
    if (oe && m_rv) chk("R6 bus_o", bus_o, m_rq);
    chk("R2 snk_valid", snk_valid, wr && snk_ready);
    if (wr && snk_ready) chk("R2 snk_data", snk_data, bus_i);
    if (sel) chk("R3 busy_o", busy_o, (sel && (m_abort || f)) || (wr && !snk_ready));
    chk("R4 abort_o", abort_o, m_abort);
  endtask

  task automatic step(input logic s_n, input logic d, input logic [W-1:0] v,
                      input logic sr, input logic sg);
    @(negedge clk);
    sel_n = s_n; dir_rd = d; bus_i = v; snk_ready = sr;
    src_valid = sg && (srcq.size() > 0);
    src_data  = (srcq.size() > 0) ? srcq[0] : '0;
    #5 compare();
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #5;
    chk("R9 abort_o", abort_o, 1'b0);
    chk("R9 bus_oe", bus_oe, 1'b0);
    chk("R9 rd_vld", rd_vld, 1'b0);
    rst_n = 1'b1;
    // R1: deselected junk, including direction toggles
    for (int i = 0; i < 4; i++) step(1'b1, i[0], W'(16'hdead + i), 1'b1, 1'b1);
    // R2/R3/R8: continuous write with sink stalls
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, W'(16'h1000 + i), (i % 3) != 1, 1'b1);
    // R8: non-continuous write
    for (int i = 0; i < 8; i++) step(i[0], 1'b0, W'(16'h2000 + i), 1'b1, 1'b1);
    step(1'b1, 1'b1, '0, 1'b1, 1'b1);   // legal switch to read while deselected
    // R6/R7: readback with source gaps
    for (int i = 0; i < 6; i++) srcq.push_back(W'(16'hab00 + i));
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1, '0, 1'b1, (i % 4) != 2);
    // R4: illegal flip read -> write while selected
    step(1'b0, 1'b0, 16'h5555, 1'b1, 1'b1);
    // R5: stay selected, writes refused
    for (int i = 0; i < 3; i++) step(1'b0, i[0], 16'h6666, 1'b1, 1'b1);
    chk("R5 abort_held", abort_o, 1'b1);
    step(1'b1, 1'b0, '0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 16'h7777, 1'b1, 1'b1);
    chk("R5 abort_cleared", abort_o, 1'b0);
    chk("R5 write_after_clear", snk_valid, 1'b1);
    // R4: flip write -> read
    step(1'b0, 1'b1, 16'h8888, 1'b1, 1'b1);
    step(1'b0, 1'b1, 16'h8889, 1'b1, 1'b1);
    step(1'b1, 1'b0, '0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, W'(16'h9000 + i), 1'b1, 1'b1);
    step(1'b1, 1'b0, '0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 count", W'(gotq.size()), W'(expq.size()));
    for (int i = 0; i < expq.size() && i < gotq.size(); i++)
      chk("R8 order", gotq[i], expq[i]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule